// File: doc/BRIEF.md
# Endpoint Configuration Header

This block holds the standard configuration header of a single endpoint function. A configuration access port presents one request at a time: a read or write, a byte offset, an access width of one, two or four bytes, and write data. The block answers every request with a one-cycle response. Reads return identity, command/status, class, header-type, base-address, interrupt and subsystem words, shifted and masked down to the requested width. Writes reach only two kinds of register: the 16-bit command register and the base address words. All other writes are dropped.

The base address registers are 64-bit pairs. A write clears every address bit below the region size, so software can size a region by writing all-ones and reading it back. The block also gates the function's interrupt. A request that arrives while the command register's interrupt-disable bit is set is held pending. It is raised when a later command write clears that bit.

A small state machine sequences the port. In `ST_IDLE` a request is accepted: a read moves to `ST_RD_RESP` and a write moves to `ST_WR_RESP`. Both response states return to `ST_IDLE` on the next clock. A request offered while the machine is in a response state is ignored.

Top module: `cfg_hdr`

## Requirements
- R1: After reset, the command register reads 0x0003 (I/O and memory enable), every base address word reads its address as zero, and no interrupt is pending. `rsp_valid` and `irq_out` are low.
- R2: Dword 0x00 reads {device ID, vendor ID} with the vendor ID in bits 15:0. Dword 0x2C reads {subsystem ID, subsystem vendor ID} in the same layout. Dword 0x08 reads the class/revision parameter.
- R3: Dword 0x04 reads {status, command}. Status bit 3 (interrupt status) is always set, and status bit 4 (capability list) is set when capabilities are present. Dword 0x34 reads 0xA4 when capabilities are present and 0 otherwise.
- R4: Dword 0x0C reads 0, which is a standard header type with a zero cache line, latency and self-test. Dword 0x3C reads 0x00000100 (interrupt pin 1 in bits 15:8). Offsets 0x28, 0x30, 0x38 and 0x40..0xFF, and any base address pair whose number is at or above the implemented count, read 0.
- R5: Offsets 0x10..0x24 form word indices 0..5. Pair number = index/2, and an odd index is the upper 32 bits. A written word keeps only the bits at or above the region size. The lower word always reports 4'b0100 in bits 3:0 (64-bit memory space).
- R6: After all-ones is written to both words of a pair, the lower word reads ~(size-1) with 4'b0100 in bits 3:0, and the upper word reads 0xFFFFFFFF for regions under 4 GiB.
- R7: A read at offset `o` of width `n` bytes returns the dword at `o & ~3`, shifted right by 8*(`o & 3`) and masked to `n` bytes.
- R8: A command write takes effect only at offset 0x04 with width 2. A base address write takes effect only at a dword-aligned offset with width 4. Every other write leaves all readable state unchanged.
- R9: While command bit 10 is clear, an `irq_req` pulse produces an `irq_out` pulse one cycle later.
- R10: While command bit 10 is set, `irq_req` raises no `irq_out` and latches a pending flag. A later accepted command write with bit 10 clear pulses `irq_out` in the response cycle and clears the flag, so a repeat of that write raises nothing.
- R11: Each accepted request produces exactly one cycle of `rsp_valid`, in the cycle after acceptance. A request held during the response cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted in ST_IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 8 | Byte offset into the header |
| req_size | input | 3 | Access width in bytes: 1, 2 or 4 |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response cycle indicator |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| irq_req | input | 1 | Function interrupt request pulse |
| irq_out | output | 1 | Interrupt raised toward the controller |

## Verification
The case that is hardest to reach from the ports is the deferred interrupt. The stimulus first sets the mask with a 16-bit command write, then pulses `irq_req` and confirms that nothing comes out. It then checks that the clearing command write itself produces the pulse, and that a second identical write does not. A reset taken with an interrupt pending shows that the flag does not survive. The size probe needs two writes and a read per word, and widths that are not allowed are driven at both writable registers to show they change nothing.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_RESP = 2'd1,
        ST_WR_RESP = 2'd2
    } hdr_state_e;

    localparam logic [7:0]  OFF_ID      = 8'h00;
    localparam logic [7:0]  OFF_CMD     = 8'h04;
    localparam logic [7:0]  OFF_CLASS   = 8'h08;
    localparam logic [7:0]  OFF_HTYPE   = 8'h0C;
    localparam logic [7:0]  OFF_BAR_LO  = 8'h10;
    localparam logic [7:0]  OFF_BAR_HI  = 8'h24;
    localparam logic [7:0]  OFF_SUBSYS  = 8'h2C;
    localparam logic [7:0]  OFF_CAPPTR  = 8'h34;
    localparam logic [7:0]  OFF_INTR    = 8'h3C;
    localparam logic [7:0]  CAP_START   = 8'hA4;
    localparam logic [15:0] CMD_RESET   = 16'h0003;
    localparam int          CMD_INT_DIS = 10;
    localparam logic [15:0] STS_INT     = 16'h0008;
    localparam logic [15:0] STS_CAPLIST = 16'h0010;
    localparam logic [3:0]  BAR_KIND    = 4'b0100;
    localparam logic [7:0]  INT_PIN     = 8'h01;

    function automatic logic [31:0] width_mask(input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_hdr_bar_bank.sv
module cfg_hdr_bar_bank #(
    parameter int                     NUM_BARS = 2,
    parameter logic [NUM_BARS*6-1:0]  BAR_LOG2 = {6'd16, 6'd12}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  word_idx,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_word
);
    import cfg_hdr_pkg::*;

    logic [NUM_BARS*32-1:0] lo_flat;
    logic [NUM_BARS*32-1:0] hi_flat;

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        localparam int          SZ_LOG2  = int'(BAR_LOG2[g*6 +: 6]);
        localparam logic [63:0] KEEP     = ~((64'd1 << SZ_LOG2) - 64'd1);
        logic [31:0] lo_q;
        logic [31:0] hi_q;
        logic        hit;

        assign hit = wr_en && (word_idx[2:1] == 2'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (hit) begin
                if (word_idx[0]) hi_q <= wr_data & KEEP[63:32];
                else             lo_q <= wr_data & KEEP[31:0];
            end
        end

        assign lo_flat[g*32 +: 32] = lo_q;
        assign hi_flat[g*32 +: 32] = hi_q;
    end

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BARS; b++) begin
            if (word_idx[2:1] == 2'(b)) begin
                rd_word = word_idx[0] ? hi_flat[b*32 +: 32]
                                      : (lo_flat[b*32 +: 32] | {28'd0, BAR_KIND});
            end
        end
    end

endmodule

// File: rtl/cfg_hdr_irq_gate.sv
module cfg_hdr_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic mask_q,
    input  logic cmd_wr,
    input  logic cmd_wr_mask,
    output logic irq_out,
    output logic pending_q
);
    logic fire;
    logic unmask_wr;
    logic pend_d;

    assign unmask_wr = cmd_wr && !cmd_wr_mask;
    assign fire      = (irq_req && !mask_q) || (unmask_wr && (pending_q || irq_req));
    assign pend_d    = unmask_wr ? 1'b0 : (pending_q || (irq_req && mask_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out   <= 1'b0;
            pending_q <= 1'b0;
        end else begin
            irq_out   <= fire;
            pending_q <= pend_d;
        end
    end

endmodule

// File: rtl/cfg_hdr.sv
module cfg_hdr #(
    parameter logic [15:0]            VEN_ID    = 16'hC0DE,
    parameter logic [15:0]            DEV_ID    = 16'hBEEF,
    parameter logic [15:0]            SUB_VEN   = 16'h5A5A,
    parameter logic [15:0]            SUB_ID    = 16'h0042,
    parameter logic [31:0]            CLASS_REV = 32'h0600_0011,
    parameter bit                     HAS_CAPS  = 1'b1,
    parameter int                     NUM_BARS  = 2,
    parameter logic [NUM_BARS*6-1:0]  BAR_LOG2  = {6'd16, 6'd12}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_off,
    input  logic [2:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    input  logic        irq_req,
    output logic        irq_out
);
    import cfg_hdr_pkg::*;

    localparam logic [15:0] STATUS_VAL = STS_INT | (HAS_CAPS ? STS_CAPLIST : 16'h0000);
    localparam logic [31:0] CAPPTR_VAL = HAS_CAPS ? {24'd0, CAP_START} : 32'd0;

    hdr_state_e  state_q, state_d;
    logic [15:0] cmd_q;
    logic        pending_q;
    logic        accept;
    logic        cmd_wr;
    logic        bar_wr;
    logic        in_bar_range;
    logic [2:0]  bar_idx;
    logic [7:0]  dw_off;
    logic [31:0] bar_word;
    logic [31:0] hdr_word;

    assign accept       = (state_q == ST_IDLE) && req_valid;
    assign dw_off       = {req_off[7:2], 2'b00};
    assign in_bar_range = (dw_off >= OFF_BAR_LO) && (dw_off <= OFF_BAR_HI);
    assign bar_idx      = req_off[4:2] - 3'd4;
    assign cmd_wr       = accept && req_write && (req_off == OFF_CMD) && (req_size == 3'd2);
    assign bar_wr       = accept && req_write && in_bar_range
                          && (req_off[1:0] == 2'b00) && (req_size == 3'd4);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = req_write ? ST_WR_RESP : ST_RD_RESP;
            ST_RD_RESP: state_d = ST_IDLE;
            ST_WR_RESP: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Command register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= CMD_RESET;
        else if (cmd_wr) cmd_q <= req_wdata[15:0];
    end

    cfg_hdr_bar_bank #(
        .NUM_BARS (NUM_BARS),
        .BAR_LOG2 (BAR_LOG2)
    ) u_bars (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bar_wr),
        .word_idx (bar_idx),
        .wr_data  (req_wdata),
        .rd_word  (bar_word)
    );

    cfg_hdr_irq_gate u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req     (irq_req),
        .mask_q      (cmd_q[CMD_INT_DIS]),
        .cmd_wr      (cmd_wr),
        .cmd_wr_mask (req_wdata[CMD_INT_DIS]),
        .irq_out     (irq_out),
        .pending_q   (pending_q)
    );

    // Header word selection.
    always_comb begin
        hdr_word = '0;
        if (in_bar_range) begin
            hdr_word = bar_word;
        end else begin
            case (dw_off)
                OFF_ID:     hdr_word = {DEV_ID, VEN_ID};
                OFF_CMD:    hdr_word = {STATUS_VAL, cmd_q};
                OFF_CLASS:  hdr_word = CLASS_REV;
                OFF_HTYPE:  hdr_word = 32'd0;
                OFF_SUBSYS: hdr_word = {SUB_ID, SUB_VEN};
                OFF_CAPPTR: hdr_word = CAPPTR_VAL;
                OFF_INTR:   hdr_word = {16'd0, INT_PIN, 8'd0};
                default:    hdr_word = 32'd0;
            endcase
        end
    end

    // Outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (accept) begin
            rsp_rdata <= req_write ? 32'd0
                       : (hdr_word >> {req_off[1:0], 3'b000}) & width_mask(req_size);
        end
    end

    assign rsp_valid = (state_q != ST_IDLE);

endmodule

// File: rtl/cfg_hdr_chk.sv
module cfg_hdr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_off,
    input logic [2:0]  req_size,
    input logic [31:0] req_wdata,
    input logic        rsp_valid,
    input logic        irq_req,
    input logic        irq_out,
    input logic [15:0] cmd_q,
    input logic        pending_q
);
    logic any_cmd_wr;
    logic clear_wr;

    assign any_cmd_wr = req_valid && !rsp_valid && req_write
                        && (req_off == 8'h04) && (req_size == 3'd2);
    assign clear_wr   = any_cmd_wr && !req_wdata[10];

    p_rsp_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_rsp_after_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ($past(irq_req) || $past(req_valid && req_write)));

    p_masked_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && cmd_q[10] && !any_cmd_wr) |=> (pending_q && !irq_out));

    p_pending_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && clear_wr) |=> (irq_out && !pending_q));

endmodule

bind cfg_hdr cfg_hdr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_off   (req_off),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .irq_req   (irq_req),
    .irq_out   (irq_out),
    .cmd_q     (cmd_q),
    .pending_q (pending_q)
);

// File: tb/cfg_hdr_bench.sv
module cfg_hdr_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_off = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq_req = 1'b0;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [31:0] got_data;
    logic        got_irq;

    always #5 clk = ~clk;

    cfg_hdr u_cfg_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_off   (req_off),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .irq_req   (irq_req),
        .irq_out   (irq_out)
    );

    // {write, offset, width, wdata, expected read, requirement}
    localparam int NV = 32;
    localparam logic [79:0] VEC [NV] = '{
        {1'b0, 8'h00, 3'd4, 32'h0, 32'hBEEF_C0DE, 4'd2},  // R2
        {1'b0, 8'h02, 3'd2, 32'h0, 32'h0000_BEEF, 4'd7},  // R7
        {1'b0, 8'h01, 3'd1, 32'h0, 32'h0000_00C0, 4'd7},  // R7
        {1'b0, 8'h04, 3'd4, 32'h0, 32'h0018_0003, 4'd1},  // R1
        {1'b0, 8'h06, 3'd2, 32'h0, 32'h0000_0018, 4'd3},  // R3
        {1'b0, 8'h08, 3'd4, 32'h0, 32'h0600_0011, 4'd2},  // R2
        {1'b0, 8'h0C, 3'd4, 32'h0, 32'h0000_0000, 4'd4},  // R4
        {1'b0, 8'h2C, 3'd4, 32'h0, 32'h0042_5A5A, 4'd2},  // R2
        {1'b0, 8'h34, 3'd4, 32'h0, 32'h0000_00A4, 4'd3},  // R3
        {1'b0, 8'h3C, 3'd4, 32'h0, 32'h0000_0100, 4'd4},  // R4
        {1'b0, 8'h3D, 3'd1, 32'h0, 32'h0000_0001, 4'd7},  // R7
        {1'b0, 8'h10, 3'd4, 32'h0, 32'h0000_0004, 4'd1},  // R1
        {1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF, 32'h0, 4'd6},  // R6
        {1'b0, 8'h10, 3'd4, 32'h0, 32'hFFFF_F004, 4'd6},  // R6
        {1'b1, 8'h14, 3'd4, 32'hFFFF_FFFF, 32'h0, 4'd6},
        {1'b0, 8'h14, 3'd4, 32'h0, 32'hFFFF_FFFF, 4'd6},  // R6
        {1'b1, 8'h18, 3'd4, 32'h1234_5678, 32'h0, 4'd5},  // R5
        {1'b0, 8'h18, 3'd4, 32'h0, 32'h1234_0004, 4'd5},  // R5
        {1'b1, 8'h1C, 3'd4, 32'h0000_ABCD, 32'h0, 4'd5},
        {1'b0, 8'h1C, 3'd4, 32'h0, 32'h0000_ABCD, 4'd5},  // R5
        {1'b0, 8'h1A, 3'd2, 32'h0, 32'h0000_1234, 4'd7},  // R7
        {1'b1, 8'h20, 3'd4, 32'hFFFF_FFFF, 32'h0, 4'd4},
        {1'b0, 8'h20, 3'd4, 32'h0, 32'h0000_0000, 4'd4},  // R4
        {1'b1, 8'h10, 3'd2, 32'h0000_0000, 32'h0, 4'd8},  // R8
        {1'b0, 8'h10, 3'd4, 32'h0, 32'hFFFF_F004, 4'd8},  // R8
        {1'b1, 8'h04, 3'd4, 32'h0000_0000, 32'h0, 4'd8},
        {1'b0, 8'h04, 3'd4, 32'h0, 32'h0018_0003, 4'd8},  // R8
        {1'b1, 8'h04, 3'd2, 32'h0000_0007, 32'h0, 4'd8},
        {1'b0, 8'h04, 3'd4, 32'h0, 32'h0018_0007, 4'd8},  // R8
        {1'b1, 8'h40, 3'd4, 32'hDEAD_BEEF, 32'h0, 4'd4},
        {1'b0, 8'h40, 3'd4, 32'h0, 32'h0000_0000, 4'd4},  // R4
        {1'b0, 8'h12, 3'd2, 32'h0, 32'h0000_FFFF, 4'd7}   // R7
    };

    task automatic check(input int rq, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic do_req(input logic w, input logic [7:0] off, input logic [2:0] sz,
                          input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_off = off; req_size = sz; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got_data = rsp_rdata;
        got_irq  = irq_out;
        if (rsp_valid !== 1'b1) check(11, {31'd0, rsp_valid}, 32'd1, "response strobe");
        @(posedge clk);
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        irq_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        irq_req = 1'b0;
        got_irq = irq_out;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++;
                checks++;
                $display("FAIL watchdog expired");
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs idle after reset
        check(1, {31'd0, rsp_valid}, 32'd0, "rsp_valid after reset");
        check(1, {31'd0, irq_out},   32'd0, "irq_out after reset");

        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i][79], VEC[i][78:71], VEC[i][70:68], VEC[i][67:36]);
            if (!VEC[i][79]) check(int'(VEC[i][3:0]), got_data, VEC[i][35:4], "table read");
        end

        // R11: back in idle after one response cycle
        @(negedge clk);
        check(11, {31'd0, rsp_valid}, 32'd0, "strobe drops after response");

        // R11: request held into the response cycle is not taken twice
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_off = 8'h00; req_size = 3'd4;
        @(posedge clk);
        @(negedge clk);
        check(11, {31'd0, rsp_valid}, 32'd1, "held request first response");
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(11, {31'd0, rsp_valid}, 32'd0, "held request ignored in response");
        @(posedge clk);

        // R9: unmasked interrupt passes through
        pulse_irq();
        check(9, {31'd0, got_irq}, 32'd1, "unmasked irq pulse");
        @(negedge clk);
        check(9, {31'd0, irq_out}, 32'd0, "irq pulse is one cycle");

        // R10: masked interrupt is deferred
        do_req(1'b1, 8'h04, 3'd2, 32'h0000_0403);
        pulse_irq();
        check(10, {31'd0, got_irq}, 32'd0, "masked irq suppressed");
        @(negedge clk);
        check(10, {31'd0, irq_out}, 32'd0, "masked irq still silent");
        do_req(1'b1, 8'h04, 3'd2, 32'h0000_0003);
        check(10, {31'd0, got_irq}, 32'd1, "unmask write releases irq");
        do_req(1'b1, 8'h04, 3'd2, 32'h0000_0003);
        check(10, {31'd0, got_irq}, 32'd0, "pending cleared after release");

        // R1: reset clears pending and registers
        do_req(1'b1, 8'h04, 3'd2, 32'h0000_0400);
        do_req(1'b1, 8'h18, 3'd4, 32'hFFFF_FFFF);
        pulse_irq();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        do_req(1'b0, 8'h04, 3'd4, 32'h0);
        check(1, got_data, 32'h0018_0003, "command after reset");
        do_req(1'b0, 8'h18, 3'd4, 32'h0);
        check(1, got_data, 32'h0000_0004, "bar after reset");
        do_req(1'b1, 8'h04, 3'd2, 32'h0000_0003);
        check(1, {31'd0, got_irq}, 32'd0, "no pending after reset");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule